// File: doc/BRIEF.md
# Link Bring-Up Speed Sequencer

This block brings up a root-port link in two stages. A `start_i` pulse restricts the maximum-speed field to first generation and turns on the link training state machine. The block then waits for a stable link-up. Once the link is up, it raises the speed cap to second generation and issues a directed speed-change request. It then polls the busy flag of that request at a fixed spacing and with a bounded number of checks. When the request has completed, it confirms link-up a second time.

If any wait expires, the block runs a PHY receiver reset before it reports failure. The reset raises the data-enable and PLL-enable override lines together, holds them for a programmable time, and then drops them. The block ends every run with a single-cycle `done_o` or `fail_o` pulse and goes back to idle. The training enable stays at the value it last had.

The link training machine and the speed-change register live outside the block. The block sees them only through the status inputs and the request pulse.

Top module: `lnk_speed_seq`

## Requirements
- R1: On `start_i` in idle, `max_speed_o` is set to 1 (first generation) before `ltssm_en_o` rises. While the first link-up wait runs, it stays at 1.
- R2: `max_speed_o` becomes 2 (second generation) only after the first link-up is accepted. It is already 2 on the cycle the speed-change request is issued. If the first link-up is never accepted, it stays 1 to the end of the run.
- R3: A link-up is accepted only while `link_up_i` is 1 and `in_training_i` is 0. If no link-up is accepted within the LINK_WAIT_CYC window, the run fails.
- R4: `spd_chg_set_o` is a single-cycle pulse. `spd_chg_busy_i` is checked every POLL_GAP_CYC+2 cycles, and the first check falls POLL_GAP_CYC+2 cycles after the request. At most POLL_MAX checks are made. If busy is still 1 at the last check, the override lines rise on the next cycle, which is POLL_MAX*(POLL_GAP_CYC+2)+1 cycles after the request. If busy is 0 on the last check, the speed change counts as complete.
- R5: After the speed change completes, link-up must be accepted again within LINK_WAIT_CYC. Success is reported only then. Otherwise the run fails.
- R6: On every failure, both `phy_rx_data_ovr_o` and `phy_rx_pll_ovr_o` rise together and stay high for PHY_HOLD_CYC+1 cycles. Both are low again when `fail_o` pulses. On success they never rise.
- R7: `done_o` and `fail_o` are one-cycle pulses and never high together. After either pulse the block is idle. `ltssm_en_o` stays 1 once it is set.
- R8: After reset, all outputs are 0 except `max_speed_o`, which is 1. Without `start_i`, no pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a bring-up run (sampled in idle) |
| link_up_i | input | 1 | Link-up status from the training machine |
| in_training_i | input | 1 | Link is still training |
| spd_chg_busy_i | input | 1 | Speed-change request bit read back; hardware clears it when done |
| max_speed_o | output | 4 | Maximum link speed field (1 = first gen, 2 = second gen) |
| ltssm_en_o | output | 1 | Link training enable |
| spd_chg_set_o | output | 1 | One-cycle pulse that sets the speed-change request bit |
| phy_rx_data_ovr_o | output | 1 | PHY receiver data-enable override |
| phy_rx_pll_ovr_o | output | 1 | PHY receiver PLL-enable override |
| done_o | output | 1 | Bring-up succeeded (one-cycle pulse) |
| fail_o | output | 1 | Bring-up failed (one-cycle pulse) |

## Verification
The retry limit and the completion of the speed change can land on the same check. This happens when the busy flag drops exactly on the cycle of the last allowed check. The bench drives two cases: busy clears in time to be seen on that final check, and busy clears one cycle later. A correct design gives completion priority in the first case, which then succeeds. In the second case it times out, and the override rise must fall on the exact cycle the spacing formula gives.

// File: rtl/lnk_seq_pkg.sv
package lnk_seq_pkg;

    localparam logic [3:0] SPD_GEN1 = 4'd1;
    localparam logic [3:0] SPD_GEN2 = 4'd2;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ARM,
        S_TRAIN1,
        S_SC_REQ,
        S_SC_GAP,
        S_SC_CHK,
        S_TRAIN2,
        S_PHY_HOLD,
        S_DONE,
        S_FAIL
    } seq_st_e;

    typedef enum logic [1:0] {
        TS_LINK,
        TS_GAP,
        TS_HOLD
    } tmr_sel_e;

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/lnk_seq_timer.sv
module lnk_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/lnk_seq_retry.sv
module lnk_seq_retry #(
    parameter int LIMIT = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int PW = $clog2(LIMIT + 1);

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + PW'(1);
        end
    end

    // this check is the final permitted one
    assign last_o = (cnt_q == PW'(LIMIT - 1));
endmodule

// File: rtl/lnk_seq_ctrl.sv
module lnk_seq_ctrl
    import lnk_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       link_ok_i,
    input  logic       sc_busy_i,
    input  logic       tmr_zero_i,
    input  logic       poll_last_i,
    output logic       tmr_load_o,
    output tmr_sel_e   tmr_sel_o,
    output logic       poll_clr_o,
    output logic       poll_inc_o,
    output logic [3:0] max_speed_o,
    output logic       ltssm_en_o,
    output logic       sc_set_o,
    output logic       ovr_o,
    output logic       done_o,
    output logic       fail_o
);
    seq_st_e    st_q, st_d;
    logic [3:0] spd_q, spd_d;
    logic       en_q, en_d;
    logic       ovr_q, ovr_d;

    always_comb begin
        st_d       = st_q;
        spd_d      = spd_q;
        en_d       = en_q;
        ovr_d      = ovr_q;
        tmr_load_o = 1'b0;
        tmr_sel_o  = TS_LINK;
        poll_clr_o = 1'b0;
        poll_inc_o = 1'b0;
        case (st_q)
            S_IDLE: begin
                if (start_i) begin
                    spd_d = SPD_GEN1;
                    st_d  = S_ARM;
                end
            end
            S_ARM: begin
                en_d       = 1'b1;
                tmr_load_o = 1'b1;
                tmr_sel_o  = TS_LINK;
                st_d       = S_TRAIN1;
            end
            S_TRAIN1: begin
                if (link_ok_i) begin
                    spd_d = SPD_GEN2;
                    st_d  = S_SC_REQ;
                end else if (tmr_zero_i) begin
                    ovr_d      = 1'b1;
                    tmr_load_o = 1'b1;
                    tmr_sel_o  = TS_HOLD;
                    st_d       = S_PHY_HOLD;
                end
            end
            S_SC_REQ: begin
                tmr_load_o = 1'b1;
                tmr_sel_o  = TS_GAP;
                poll_clr_o = 1'b1;
                st_d       = S_SC_GAP;
            end
            S_SC_GAP: begin
                if (tmr_zero_i) begin
                    st_d = S_SC_CHK;
                end
            end
            S_SC_CHK: begin
                poll_inc_o = 1'b1;
                if (!sc_busy_i) begin
                    tmr_load_o = 1'b1;
                    tmr_sel_o  = TS_LINK;
                    st_d       = S_TRAIN2;
                end else if (poll_last_i) begin
                    ovr_d      = 1'b1;
                    tmr_load_o = 1'b1;
                    tmr_sel_o  = TS_HOLD;
                    st_d       = S_PHY_HOLD;
                end else begin
                    tmr_load_o = 1'b1;
                    tmr_sel_o  = TS_GAP;
                    st_d       = S_SC_GAP;
                end
            end
            S_TRAIN2: begin
                if (link_ok_i) begin
                    st_d = S_DONE;
                end else if (tmr_zero_i) begin
                    ovr_d      = 1'b1;
                    tmr_load_o = 1'b1;
                    tmr_sel_o  = TS_HOLD;
                    st_d       = S_PHY_HOLD;
                end
            end
            S_PHY_HOLD: begin
                if (tmr_zero_i) begin
                    ovr_d = 1'b0;
                    st_d  = S_FAIL;
                end
            end
            S_DONE:  st_d = S_IDLE;
            S_FAIL:  st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= S_IDLE;
            spd_q <= SPD_GEN1;
            en_q  <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            spd_q <= spd_d;
            en_q  <= en_d;
            ovr_q <= ovr_d;
        end
    end

    assign max_speed_o = spd_q;
    assign ltssm_en_o  = en_q;
    assign ovr_o       = ovr_q;
    assign sc_set_o    = (st_q == S_SC_REQ);
    assign done_o      = (st_q == S_DONE);
    assign fail_o      = (st_q == S_FAIL);
endmodule

// File: rtl/lnk_speed_seq.sv
module lnk_speed_seq
    import lnk_seq_pkg::*;
#(
    parameter int LINK_WAIT_CYC = 20000,
    parameter int POLL_GAP_CYC  = 20000,
    parameter int POLL_MAX      = 200,
    parameter int PHY_HOLD_CYC  = 500000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       link_up_i,
    input  logic       in_training_i,
    input  logic       spd_chg_busy_i,
    output logic [3:0] max_speed_o,
    output logic       ltssm_en_o,
    output logic       spd_chg_set_o,
    output logic       phy_rx_data_ovr_o,
    output logic       phy_rx_pll_ovr_o,
    output logic       done_o,
    output logic       fail_o
);
    localparam int TW = $clog2(max3(LINK_WAIT_CYC, POLL_GAP_CYC, PHY_HOLD_CYC) + 1);

    logic          link_ok;
    logic          tmr_load, tmr_zero;
    tmr_sel_e      tmr_sel;
    logic [TW-1:0] tmr_val;
    logic          poll_clr, poll_inc, poll_last;
    logic          ovr;

    assign link_ok = link_up_i & ~in_training_i;

    always_comb begin
        case (tmr_sel)
            TS_GAP:  tmr_val = TW'(POLL_GAP_CYC);
            TS_HOLD: tmr_val = TW'(PHY_HOLD_CYC);
            default: tmr_val = TW'(LINK_WAIT_CYC);
        endcase
    end

    lnk_seq_timer #(.W(TW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    lnk_seq_retry #(.LIMIT(POLL_MAX)) u_retry (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (poll_clr),
        .inc_i  (poll_inc),
        .last_o (poll_last)
    );

    lnk_seq_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .link_ok_i   (link_ok),
        .sc_busy_i   (spd_chg_busy_i),
        .tmr_zero_i  (tmr_zero),
        .poll_last_i (poll_last),
        .tmr_load_o  (tmr_load),
        .tmr_sel_o   (tmr_sel),
        .poll_clr_o  (poll_clr),
        .poll_inc_o  (poll_inc),
        .max_speed_o (max_speed_o),
        .ltssm_en_o  (ltssm_en_o),
        .sc_set_o    (spd_chg_set_o),
        .ovr_o       (ovr),
        .done_o      (done_o),
        .fail_o      (fail_o)
    );

    assign phy_rx_data_ovr_o = ovr;
    assign phy_rx_pll_ovr_o  = ovr;
endmodule

// File: rtl/lnk_speed_seq_chk.sv
module lnk_speed_seq_chk
    import lnk_seq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       link_up_i,
    input logic       in_training_i,
    input logic [3:0] max_speed_o,
    input logic       ltssm_en_o,
    input logic       spd_chg_set_o,
    input logic       phy_rx_data_ovr_o,
    input logic       phy_rx_pll_ovr_o,
    input logic       done_o,
    input logic       fail_o
);
    a_r1_gen1_at_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(ltssm_en_o) |-> max_speed_o == SPD_GEN1);

    a_r2_gen2_at_request: assert property (@(posedge clk) disable iff (rst)
        spd_chg_set_o |-> max_speed_o == SPD_GEN2);

    a_r4_request_single: assert property (@(posedge clk) disable iff (rst)
        spd_chg_set_o |=> !spd_chg_set_o);

    a_r5_done_after_link: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(link_up_i && !in_training_i));

    a_r6_override_clear_at_fail: assert property (@(posedge clk) disable iff (rst)
        fail_o |-> (!phy_rx_data_ovr_o && !phy_rx_pll_ovr_o));

    a_r6_no_override_at_done: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !$past(phy_rx_data_ovr_o));

    a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done_o && fail_o));

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r7_fail_pulse: assert property (@(posedge clk) disable iff (rst)
        fail_o |=> !fail_o);

    a_r7_enable_sticky: assert property (@(posedge clk) disable iff (rst)
        ltssm_en_o |=> ltssm_en_o);
endmodule

bind lnk_speed_seq lnk_speed_seq_chk u_chk (
    .clk               (clk),
    .rst               (rst),
    .link_up_i         (link_up_i),
    .in_training_i     (in_training_i),
    .max_speed_o       (max_speed_o),
    .ltssm_en_o        (ltssm_en_o),
    .spd_chg_set_o     (spd_chg_set_o),
    .phy_rx_data_ovr_o (phy_rx_data_ovr_o),
    .phy_rx_pll_ovr_o  (phy_rx_pll_ovr_o),
    .done_o            (done_o),
    .fail_o            (fail_o)
);

// File: tb/lnk_speed_seq_bench.sv
`timescale 1ns/1ps
module lnk_speed_seq_bench;
    localparam int LW = 40;
    localparam int GAP = 3;
    localparam int PMAX = 200;
    localparam int HOLD = 50;
    localparam logic [15:0] NEVER = 16'hFFFF;

    typedef struct packed {
        logic [15:0] up1;    // cycles after start until first link-up
        logic        tr1;    // in-training stuck high in first phase
        logic [15:0] clr;    // cycles after request until busy clears
        logic        drop2;  // link lost after speed change
        logic        ok;     // expected success
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{16'd5,  1'b0, 16'd10,   1'b0, 1'b1},
        '{16'd30, 1'b0, 16'd900,  1'b0, 1'b1},
        '{NEVER,  1'b0, 16'd10,   1'b0, 1'b0},
        '{16'd5,  1'b1, 16'd10,   1'b0, 1'b0},
        '{16'd5,  1'b0, NEVER,    1'b0, 1'b0},
        '{16'd5,  1'b0, 16'd10,   1'b1, 1'b0},
        '{16'd0,  1'b0, 16'd1,    1'b0, 1'b1},
        '{16'd5,  1'b0, 16'd1000, 1'b0, 1'b1},
        '{16'd5,  1'b0, 16'd1001, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       link_up_i = 1'b0;
    logic       in_training_i = 1'b0;
    logic       spd_chg_busy_i = 1'b0;
    logic [3:0] max_speed_o;
    logic       ltssm_en_o, spd_chg_set_o, phy_rx_data_ovr_o, phy_rx_pll_ovr_o;
    logic       done_o, fail_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    lnk_speed_seq #(
        .LINK_WAIT_CYC (LW),
        .POLL_GAP_CYC  (GAP),
        .POLL_MAX      (PMAX),
        .PHY_HOLD_CYC  (HOLD)
    ) u_lnk_speed_seq (
        .clk               (clk),
        .rst               (rst),
        .start_i           (start_i),
        .link_up_i         (link_up_i),
        .in_training_i     (in_training_i),
        .spd_chg_busy_i    (spd_chg_busy_i),
        .max_speed_o       (max_speed_o),
        .ltssm_en_o        (ltssm_en_o),
        .spd_chg_set_o     (spd_chg_set_o),
        .phy_rx_data_ovr_o (phy_rx_data_ovr_o),
        .phy_rx_pll_ovr_o  (phy_rx_pll_ovr_o),
        .done_o            (done_o),
        .fail_o            (fail_o)
    );

    task automatic check(input logic cond, input string req, input int act, input int exp);
        n_chk++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_vec(input int idx);
        vec_t v;
        bit   sc_seen, busy, fin, ovr_mismatch;
        int   sc_cnt, set_pulses, ovr_cyc, cyc_set, cyc_ovr, end_spd;
        bit   got_done, got_fail, accepted;
        v = VECS[idx];
        sc_seen = 0; busy = 0; fin = 0; ovr_mismatch = 0;
        sc_cnt = 0; set_pulses = 0; ovr_cyc = 0; cyc_set = -1; cyc_ovr = -1;
        got_done = 0; got_fail = 0; end_spd = 0;
        accepted = (v.up1 != NEVER) && !v.tr1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 1; c < 6000 && !fin; c++) begin
            if (c == 1)
                check(max_speed_o == 4'd1, "R1 gen1 cap after start", max_speed_o, 1);
            if (c == 3)
                check(ltssm_en_o == 1'b1, "R1 training enabled", ltssm_en_o, 1);
            if (phy_rx_data_ovr_o) begin
                ovr_cyc++;
                if (cyc_ovr < 0) cyc_ovr = c;
            end
            if (phy_rx_data_ovr_o != phy_rx_pll_ovr_o) ovr_mismatch = 1;
            if (done_o && fail_o)
                check(1'b0, "R7 done and fail together", 1, 0);
            if (done_o || fail_o) begin
                got_done = done_o; got_fail = fail_o; end_spd = max_speed_o;
                fin = 1;
            end
            if (spd_chg_set_o) begin
                set_pulses++;
                check(max_speed_o == 4'd2, "R2 gen2 at request", max_speed_o, 2);
                busy = 1; sc_cnt = 0; sc_seen = 1; cyc_set = c;
            end else if (busy) begin
                sc_cnt++;
                if (v.clr != NEVER && sc_cnt >= int'(v.clr)) busy = 0;
            end
            if (!sc_seen) begin
                link_up_i     = (v.up1 != NEVER) && (c >= int'(v.up1));
                in_training_i = v.tr1;
            end else if (busy) begin
                link_up_i     = 1'b1;
                in_training_i = 1'b1;
            end else begin
                link_up_i     = !v.drop2;
                in_training_i = 1'b0;
            end
            spd_chg_busy_i = busy;
            if (!fin) @(negedge clk);
        end
        // R7 / R3 / R5 outcome
        check(got_done == v.ok && got_fail == !v.ok, "R7 outcome", got_done, v.ok);
        check(end_spd == (accepted ? 2 : 1), "R2 final speed cap", end_spd, accepted ? 2 : 1);
        check(ovr_cyc == (v.ok ? 0 : HOLD + 1), "R6 override hold", ovr_cyc, v.ok ? 0 : HOLD + 1);
        check(!ovr_mismatch, "R6 overrides move together", ovr_mismatch, 0);
        check(set_pulses == (accepted ? 1 : 0), "R4 single request pulse", set_pulses, accepted ? 1 : 0);
        if (v.clr == NEVER || v.clr == 16'd1001)
            check(cyc_ovr - cyc_set == PMAX * (GAP + 2) + 1, "R4 poll limit timing",
                  cyc_ovr - cyc_set, PMAX * (GAP + 2) + 1);
        @(negedge clk);
        check(!done_o && !fail_o, "R7 pulse width", done_o | fail_o, 0);
        check(ltssm_en_o == 1'b1, "R7 enable held", ltssm_en_o, 1);
        for (int k = 0; k < 3; k++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R8 reset state
        check(max_speed_o == 4'd1, "R8 reset speed", max_speed_o, 1);
        check(!ltssm_en_o, "R8 reset enable", ltssm_en_o, 0);
        check(!spd_chg_set_o, "R8 reset request", spd_chg_set_o, 0);
        check(!phy_rx_data_ovr_o && !phy_rx_pll_ovr_o, "R8 reset overrides", phy_rx_data_ovr_o, 0);
        begin
            int pulses;
            pulses = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (done_o || fail_o || ltssm_en_o) pulses++;
            end
            check(pulses == 0, "R8 idle without start", pulses, 0);
        end
        for (int i = 0; i < NV; i++) run_vec(i);
        // R3: in-training alone blocks acceptance even after reset of enable
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!ltssm_en_o, "R8 enable cleared by reset", ltssm_en_o, 0);
        run_vec(3);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule